// File: doc/BRIEF.md
# Bus Target Address-Phase Decoder

This block is the front end of a target on a multiplexed address/data bus. It watches for the start of each transaction, latches the command and the address, and decides whether this device takes part. When it does, it raises device-select a set number of clock edges after the address, depending on a latency class chosen at run time. A 64-bit address arrives in two consecutive words. The first word carries a dual-address command code, and the second word carries the real command and the upper address half.

Memory and I/O accesses are matched against a base/mask window. Configuration accesses are taken only when the slot select input is high. In subtractive mode the block takes its window only when no other device has answered by the last positive-decode slot. When nobody answers at all, it flags the access as a master abort. For reads it also gives the edge from which the target may drive data, and it keeps the turnaround cycle free.

Top module: `tgt_addr_decode`

## Requirements
- R1: A transaction starts at the rising edge where `frame_i` is sampled high after having been low. Command, address word and `idsel_i` are latched at that edge, and the bus values are ignored afterwards. For a dual-address transaction the reference edge ("edge 0") is the next edge, which latches the second word. In every other case edge 0 is the start edge. Edge k is the k-th rising edge after edge 0.
- R2: The latency class `speed_i` is 0 (fast), 1 (medium), or 2 or 3 (slow). A positive claim raises `devsel_o` after edge 1, 2 or 3 respectively.
- R3: `hit_o` is high from edge 1 until the next transaction when the window matches: `((A ^ bar_base_i) & bar_mask_i) == 0`, and the command class agrees with `bar_is_io_i`. Memory commands are 0110, 0111, 1100, 1110 and 1111. I/O commands are 0010 and 0011. For a single-word address, A has its upper half zero.
- R4: A configuration command (1010 read, 1011 write) is claimed only if `idsel_i` was high at the start edge and the access is not dual-address. `cfg_off_o` is the low `CFG_OFF_W` address bits, and the upper address bits have no effect. `cfg_sel_o` follows `devsel_o` for such a claim.
- R5: Command 1101 on the first word marks a dual-address transaction, and the real command comes on the second word. If the upper address half is zero, the access never hits. With `SUPPORT_DAC` = 0, dual-address accesses never hit.
- R6: With `sub_en_i` high, window hits are not claimed positively. They are claimed at edge S instead, where S = 4, or S = 3 when `sub_early_i` is high. This happens only if `other_devsel_i` was low at every edge from 1 to S.
- R7: `abort_o` pulses for one cycle after edge S when this block has not claimed and `other_devsel_i` was low at edges 1 to S.
- R8: `data_oe_o` is high only on claimed reads (command bit 0 = 0). It is never high after edge 1. It rises after the later of the claim edge and edge 2.
- R9: `claim_o` pulses for one cycle together with the rise of `devsel_o`. `devsel_o` and `data_oe_o` stay high until the first edge after the claim where `frame_i` is sampled low.
- R10: While reset is active, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Transaction in progress, active high |
| cmd_i | input | 4 | Bus command |
| ad_i | input | AD_W | Multiplexed address word |
| idsel_i | input | 1 | Slot select for configuration accesses |
| other_devsel_i | input | 1 | Device-select observed from other targets |
| speed_i | input | 2 | Latency class: 0 fast, 1 medium, 2/3 slow |
| sub_en_i | input | 1 | Subtractive decoding of the window |
| sub_early_i | input | 1 | All other targets medium or faster: subtractive slot at edge 3 |
| bar_is_io_i | input | 1 | Window decodes I/O commands instead of memory |
| bar_base_i | input | 2*AD_W | Window base address |
| bar_mask_i | input | 2*AD_W | Window compare mask |
| claim_o | output | 1 | One-cycle pulse when this device claims |
| devsel_o | output | 1 | Device-select |
| hit_o | output | 1 | Window hit flag for the latched address |
| cfg_sel_o | output | 1 | Current claim is a configuration access |
| cfg_off_o | output | CFG_OFF_W | Configuration register offset |
| data_oe_o | output | 1 | Target may drive read data |
| abort_o | output | 1 | One-cycle pulse: nobody claimed (master abort) |

## Verification
A wrong phase count or a wrong latched command shows at the ports within four edges of the address phase. `devsel_o` or `claim_o` moves to a different edge, `data_oe_o` appears in the turnaround cycle, or `abort_o` fires where a claim belongs. A stale "other device seen" flag or a wrong dual-address flag changes whether the subtractive slot claims or aborts. The bench's per-edge model therefore sees such a fault in the same transaction. Configuration offsets and window hits are compared one edge after the address, while junk is already on the bus.

// File: rtl/tad_pkg.sv
package tad_pkg;

   localparam int PH_CNT_W = 3;
   localparam logic [PH_CNT_W-1:0] TURN_EDGE    = 3'd2;
   localparam logic [PH_CNT_W-1:0] SLOWEST_EDGE = 3'd3;

   localparam logic [3:0] CMD_IO_RD   = 4'b0010;
   localparam logic [3:0] CMD_IO_WR   = 4'b0011;
   localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
   localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
   localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
   localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
   localparam logic [3:0] CMD_DUAL    = 4'b1101;
   localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
   localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

   typedef enum logic [1:0] {SPD_FAST, SPD_MED, SPD_SLOW, SPD_SLOW_ALT} speed_e;
   typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_OWN, PH_DRAIN} phase_e;

   typedef struct packed {
      logic [3:0] cmd;
      logic       idsel;
      logic       dual;
   } hdr_t;

   function automatic logic is_mem_cmd(input logic [3:0] c);
      return (c == CMD_MEM_RD) || (c == CMD_MEM_WR) || (c == CMD_MEM_RDM) ||
             (c == CMD_MEM_RDL) || (c == CMD_MEM_WRI);
   endfunction

   function automatic logic is_io_cmd(input logic [3:0] c);
      return (c == CMD_IO_RD) || (c == CMD_IO_WR);
   endfunction

   function automatic logic is_cfg_cmd(input logic [3:0] c);
      return (c == CMD_CFG_RD) || (c == CMD_CFG_WR);
   endfunction

   function automatic logic [PH_CNT_W-1:0] lat_of(input speed_e s);
      case (s)
         SPD_FAST: return 3'd1;
         SPD_MED:  return 3'd2;
         default:  return SLOWEST_EDGE;
      endcase
   endfunction

endpackage

// File: rtl/tad_capture.sv
module tad_capture
   import tad_pkg::*;
#(
   parameter int AD_W        = 32,
   parameter bit SUPPORT_DAC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic [3:0]        cmd_i,
   input  logic [AD_W-1:0]   ad_i,
   input  logic              idsel_i,
   output hdr_t              hdr_o,
   output logic [2*AD_W-1:0] addr_o,
   output logic              valid_o
);

   logic            frame_d_q;
   logic            want_hi_q;
   logic            start_w;
   logic            load_hi_w;
   logic            clear_hi_w;
   logic [AD_W-1:0] lo_q;
   logic [AD_W-1:0] hi_w;

   assign start_w    = frame_i && !frame_d_q && !want_hi_q;
   assign load_hi_w  = want_hi_q;
   assign clear_hi_w = start_w && (cmd_i != CMD_DUAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_d_q <= 1'b0;
         want_hi_q <= 1'b0;
         valid_o   <= 1'b0;
         hdr_o     <= '0;
         lo_q      <= '0;
      end else begin
         frame_d_q <= frame_i;
         valid_o   <= 1'b0;
         if (want_hi_q) begin
            want_hi_q <= 1'b0;
            hdr_o.cmd <= cmd_i;
            valid_o   <= 1'b1;
         end else if (start_w) begin
            lo_q        <= ad_i;
            hdr_o.cmd   <= cmd_i;
            hdr_o.idsel <= idsel_i;
            if (cmd_i == CMD_DUAL) begin
               hdr_o.dual <= 1'b1;
               want_hi_q  <= 1'b1;
            end else begin
               hdr_o.dual <= 1'b0;
               valid_o    <= 1'b1;
            end
         end
      end
   end

   generate
      if (SUPPORT_DAC) begin : g_hi_reg
         logic [AD_W-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          hi_q <= '0;
            else if (load_hi_w)  hi_q <= ad_i;
            else if (clear_hi_w) hi_q <= '0;
         end
         assign hi_w = hi_q;
      end else begin : g_hi_zero
         assign hi_w = '0;
      end
   endgenerate

   assign addr_o = {hi_w, lo_q};

endmodule

// File: rtl/tad_range_match.sv
module tad_range_match
   import tad_pkg::*;
#(
   parameter int AD_W        = 32,
   parameter bit SUPPORT_DAC = 1'b1
) (
   input  hdr_t              hdr_i,
   input  logic [2*AD_W-1:0] addr_i,
   input  logic              bar_is_io_i,
   input  logic [2*AD_W-1:0] bar_base_i,
   input  logic [2*AD_W-1:0] bar_mask_i,
   output logic              range_hit_o,
   output logic              cfg_hit_o
);

   localparam int ADDR_W = 2 * AD_W;

   logic              class_ok_w;
   logic              window_w;
   logic              dual_ok_w;
   logic [ADDR_W-1:0] diff_w;

   assign class_ok_w = bar_is_io_i ? is_io_cmd(hdr_i.cmd) : is_mem_cmd(hdr_i.cmd);
   assign diff_w     = (addr_i ^ bar_base_i) & bar_mask_i;
   assign window_w   = (diff_w == '0);

   generate
      if (SUPPORT_DAC) begin : g_dual_legal
         assign dual_ok_w = |addr_i[ADDR_W-1:AD_W];
      end else begin : g_dual_refused
         assign dual_ok_w = 1'b0;
      end
   endgenerate

   assign range_hit_o = class_ok_w && window_w && (!hdr_i.dual || dual_ok_w);
   assign cfg_hit_o   = is_cfg_cmd(hdr_i.cmd) && hdr_i.idsel && !hdr_i.dual;

endmodule

// File: rtl/tad_phase_timer.sv
module tad_phase_timer
   import tad_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_i,
   input  logic       valid_i,
   input  logic       read_i,
   input  logic       cfg_hit_i,
   input  logic       range_hit_i,
   input  logic       other_devsel_i,
   input  logic [1:0] speed_i,
   input  logic       sub_en_i,
   input  logic       sub_early_i,
   output logic       claim_o,
   output logic       devsel_o,
   output logic       data_oe_o,
   output logic       abort_o,
   output logic       cfg_sel_o
);

   phase_e              phase_q;
   logic [PH_CNT_W-1:0] cnt_q;
   logic                seen_q;
   logic [PH_CNT_W-1:0] k_w;
   logic [PH_CNT_W-1:0] lat_w;
   logic [PH_CNT_W-1:0] sub_edge_w;
   logic                active_w;
   logic                other_now_w;
   logic                pos_take_w;
   logic                sub_take_w;
   logic                take_w;
   logic                quit_w;

   always_comb begin
      k_w         = (phase_q == PH_IDLE) ? PH_CNT_W'(1) : cnt_q;
      lat_w       = lat_of(speed_e'(speed_i));
      sub_edge_w  = sub_early_i ? SLOWEST_EDGE : SLOWEST_EDGE + PH_CNT_W'(1);
      active_w    = ((phase_q == PH_IDLE) && valid_i) || (phase_q == PH_WAIT);
      other_now_w = seen_q || other_devsel_i;
      pos_take_w  = active_w && (k_w == lat_w) &&
                    (cfg_hit_i || (range_hit_i && !sub_en_i));
      sub_take_w  = active_w && (k_w == sub_edge_w) && sub_en_i &&
                    range_hit_i && !cfg_hit_i && !other_now_w;
      take_w      = pos_take_w || sub_take_w;
      quit_w      = active_w && (k_w == sub_edge_w) && !take_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         seen_q    <= 1'b0;
         claim_o   <= 1'b0;
         devsel_o  <= 1'b0;
         data_oe_o <= 1'b0;
         abort_o   <= 1'b0;
         cfg_sel_o <= 1'b0;
      end else begin
         claim_o <= 1'b0;
         abort_o <= 1'b0;
         if (active_w) begin
            seen_q <= other_now_w;
            cnt_q  <= k_w + PH_CNT_W'(1);
            if (take_w) begin
               phase_q   <= PH_OWN;
               claim_o   <= 1'b1;
               devsel_o  <= 1'b1;
               cfg_sel_o <= cfg_hit_i;
               data_oe_o <= read_i && (k_w >= TURN_EDGE);
            end else if (quit_w) begin
               phase_q <= PH_DRAIN;
               abort_o <= !other_now_w;
            end else begin
               phase_q <= PH_WAIT;
            end
         end else begin
            case (phase_q)
               PH_OWN: begin
                  if (!frame_i) begin
                     phase_q   <= PH_IDLE;
                     devsel_o  <= 1'b0;
                     data_oe_o <= 1'b0;
                     cfg_sel_o <= 1'b0;
                     seen_q    <= 1'b0;
                  end else begin
                     data_oe_o <= read_i;
                  end
               end
               PH_DRAIN: begin
                  if (!frame_i) begin
                     phase_q <= PH_IDLE;
                     seen_q  <= 1'b0;
                  end
               end
               default: begin
                  seen_q <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/tgt_addr_decode.sv
module tgt_addr_decode
   import tad_pkg::*;
#(
   parameter int AD_W        = 32,
   parameter int CFG_OFF_W   = 8,
   parameter bit SUPPORT_DAC = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_i,
   input  logic [3:0]           cmd_i,
   input  logic [AD_W-1:0]      ad_i,
   input  logic                 idsel_i,
   input  logic                 other_devsel_i,
   input  logic [1:0]           speed_i,
   input  logic                 sub_en_i,
   input  logic                 sub_early_i,
   input  logic                 bar_is_io_i,
   input  logic [2*AD_W-1:0]    bar_base_i,
   input  logic [2*AD_W-1:0]    bar_mask_i,
   output logic                 claim_o,
   output logic                 devsel_o,
   output logic                 hit_o,
   output logic                 cfg_sel_o,
   output logic [CFG_OFF_W-1:0] cfg_off_o,
   output logic                 data_oe_o,
   output logic                 abort_o
);

   localparam int ADDR_W = 2 * AD_W;

   generate
      if (AD_W < 16) begin : g_bad_width
         $error("tgt_addr_decode: AD_W must be at least 16");
      end
      if (CFG_OFF_W < 2 || CFG_OFF_W > AD_W) begin : g_bad_off
         $error("tgt_addr_decode: CFG_OFF_W must lie between 2 and AD_W");
      end
   endgenerate

   hdr_t              hdr_w;
   logic [ADDR_W-1:0] addr_w;
   logic              valid_w;
   logic              range_hit_w;
   logic              cfg_hit_w;

   tad_capture #(
      .AD_W        (AD_W),
      .SUPPORT_DAC (SUPPORT_DAC)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_i (frame_i),
      .cmd_i   (cmd_i),
      .ad_i    (ad_i),
      .idsel_i (idsel_i),
      .hdr_o   (hdr_w),
      .addr_o  (addr_w),
      .valid_o (valid_w)
   );

   tad_range_match #(
      .AD_W        (AD_W),
      .SUPPORT_DAC (SUPPORT_DAC)
   ) u_match (
      .hdr_i       (hdr_w),
      .addr_i      (addr_w),
      .bar_is_io_i (bar_is_io_i),
      .bar_base_i  (bar_base_i),
      .bar_mask_i  (bar_mask_i),
      .range_hit_o (range_hit_w),
      .cfg_hit_o   (cfg_hit_w)
   );

   tad_phase_timer u_timer (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_i        (frame_i),
      .valid_i        (valid_w),
      .read_i         (!hdr_w.cmd[0]),
      .cfg_hit_i      (cfg_hit_w),
      .range_hit_i    (range_hit_w),
      .other_devsel_i (other_devsel_i),
      .speed_i        (speed_i),
      .sub_en_i       (sub_en_i),
      .sub_early_i    (sub_early_i),
      .claim_o        (claim_o),
      .devsel_o       (devsel_o),
      .data_oe_o      (data_oe_o),
      .abort_o        (abort_o),
      .cfg_sel_o      (cfg_sel_o)
   );

   assign hit_o     = range_hit_w;
   assign cfg_off_o = addr_w[CFG_OFF_W-1:0];

endmodule

// File: rtl/tgt_addr_decode_chk.sv
module tgt_addr_decode_chk #(
   parameter int AD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_i,
   input logic              valid_i,
   input logic              dual_i,
   input logic [2*AD_W-1:0] addr_i,
   input logic              other_devsel_i,
   input logic              sub_en_i,
   input logic              claim_o,
   input logic              devsel_o,
   input logic              data_oe_o,
   input logic              abort_o,
   input logic              cfg_sel_o
);

   p_claim_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
      claim_o |-> devsel_o && !$past(devsel_o));

   p_devsel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      devsel_o && frame_i |=> devsel_o);

   p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> !data_oe_o);

   p_oe_with_devsel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> devsel_o);

   p_abort_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !devsel_o && !claim_o);

   p_cfg_under_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel_o |-> devsel_o);

   p_dual_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_o && dual_i |-> (addr_i[2*AD_W-1:AD_W] != '0));

   p_sub_unopposed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      claim_o && sub_en_i && !cfg_sel_o |-> !$past(other_devsel_i));

endmodule

bind tgt_addr_decode tgt_addr_decode_chk #(.AD_W(AD_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_i        (frame_i),
   .valid_i        (valid_w),
   .dual_i         (hdr_w.dual),
   .addr_i         (addr_w),
   .other_devsel_i (other_devsel_i),
   .sub_en_i       (sub_en_i),
   .claim_o        (claim_o),
   .devsel_o       (devsel_o),
   .data_oe_o      (data_oe_o),
   .abort_o        (abort_o),
   .cfg_sel_o      (cfg_sel_o)
);

// File: tb/tgt_addr_decode_tb_top.sv
`timescale 1ns/1ps
module tgt_addr_decode_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_i = 1'b0;
   logic [3:0]  cmd_i = '0;
   logic [31:0] ad_i = '0;
   logic        idsel_i = 1'b0;
   logic        other_devsel_i = 1'b0;
   logic [1:0]  speed_i = '0;
   logic        sub_en_i = 1'b0;
   logic        sub_early_i = 1'b0;
   logic        bar_is_io_i = 1'b0;
   logic [63:0] bar_base_i = 64'h0000_0000_8000_0000;
   logic [63:0] bar_mask_i = 64'hFFFF_FFFF_FFF0_0000;
   logic        claim_o, devsel_o, hit_o, cfg_sel_o, data_oe_o, abort_o;
   logic [7:0]  cfg_off_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tgt_addr_decode dut_i (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .cmd_i(cmd_i), .ad_i(ad_i),
      .idsel_i(idsel_i), .other_devsel_i(other_devsel_i), .speed_i(speed_i),
      .sub_en_i(sub_en_i), .sub_early_i(sub_early_i), .bar_is_io_i(bar_is_io_i),
      .bar_base_i(bar_base_i), .bar_mask_i(bar_mask_i), .claim_o(claim_o),
      .devsel_o(devsel_o), .hit_o(hit_o), .cfg_sel_o(cfg_sel_o),
      .cfg_off_o(cfg_off_o), .data_oe_o(data_oe_o), .abort_o(abort_o)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural model: one transaction, compared after every edge 1..8.
   task automatic run_txn(input logic [3:0] c, input logic dual,
                          input logic [31:0] lo, input logic [31:0] hi,
                          input logic sel, input int other_at, input string req);
      logic [63:0] full;
      bit mem_c, io_c, hit, cfgc, by_s, ab, rd;
      int lat, s, kc;
      full  = dual ? {hi, lo} : {32'h0, lo};
      mem_c = (c == 4'h6) || (c == 4'h7) || (c == 4'hC) || (c == 4'hE) || (c == 4'hF);
      io_c  = (c == 4'h2) || (c == 4'h3);
      hit   = (bar_is_io_i ? io_c : mem_c) && (((full ^ bar_base_i) & bar_mask_i) == 64'h0)
              && (!dual || hi != 32'h0);
      cfgc  = ((c == 4'hA) || (c == 4'hB)) && sel && !dual;
      lat   = (speed_i == 2'd0) ? 1 : (speed_i == 2'd1) ? 2 : 3;
      s     = sub_early_i ? 3 : 4;
      by_s  = (other_at != 0) && (other_at <= s);
      if (cfgc)                          kc = lat;
      else if (hit && !sub_en_i)         kc = lat;
      else if (hit && sub_en_i && !by_s) kc = s;
      else                               kc = 0;
      ab = (kc == 0) && !by_s;
      rd = !c[0];

      @(negedge clk);
      frame_i = 1'b1;
      idsel_i = sel;
      if (dual) begin
         cmd_i = 4'hD; ad_i = lo;
         @(negedge clk);
         idsel_i = 1'b0;
         cmd_i = c; ad_i = hi;
      end else begin
         cmd_i = c; ad_i = lo;
      end
      @(negedge clk);                    // after edge 0: bus carries junk now (R1)
      cmd_i = ~c; ad_i = ~lo; idsel_i = ~sel;
      other_devsel_i = (other_at == 1);
      for (int k = 1; k <= 8; k++) begin
         bit edv;
         @(negedge clk);
         edv = (kc != 0) && (k >= kc) && (k <= 6);
         check(req, "claim_o (R9)",   claim_o,   (kc != 0) && (k == kc));
         check(req, "devsel_o (R2)",  devsel_o,  edv);
         check(req, "data_oe_o (R8)", data_oe_o, rd && edv && (k >= 2));
         check(req, "abort_o (R7)",   abort_o,   ab && (k == s));
         check(req, "cfg_sel_o (R4)", cfg_sel_o, cfgc && edv);
         if (k == 1) begin
            check(req, "hit_o (R3)", hit_o, hit);
            if (cfgc) check(req, "cfg_off_o (R4)", cfg_off_o, lo[7:0]);
         end
         other_devsel_i = (other_at != 0) && (k + 1 >= other_at);
         frame_i = (k + 1 <= 6);
      end
      other_devsel_i = 1'b0;
      idsel_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs low while reset is active
      check("R10", "claim", claim_o, 0);
      check("R10", "devsel", devsel_o, 0);
      check("R10", "oe", data_oe_o, 0);
      check("R10", "abort", abort_o, 0);
      check("R10", "cfg_sel", cfg_sel_o, 0);
      check("R10", "hit", hit_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      speed_i = 2'd0; run_txn(4'h6, 0, 32'h8001_2340, 0, 0, 0, "R2 fast read");
      speed_i = 2'd1; run_txn(4'h7, 0, 32'h800F_FFFC, 0, 0, 0, "R2 medium write");
      speed_i = 2'd2; run_txn(4'hE, 0, 32'h8000_0000, 0, 0, 0, "R2 slow read");
      speed_i = 2'd3; run_txn(4'hC, 0, 32'h8004_0000, 0, 0, 0, "R2 slow alt read");
      speed_i = 2'd0;
      run_txn(4'h6, 0, 32'h9000_0000, 0, 0, 0, "R7 miss abort");
      run_txn(4'h6, 0, 32'h9000_0000, 0, 0, 2, "R7 miss other claims");
      run_txn(4'hA, 0, 32'hABCD_E0F4, 0, 1, 0, "R4 cfg read fast");
      speed_i = 2'd2;
      run_txn(4'hB, 0, 32'h1234_5608, 0, 1, 0, "R4 cfg write slow");
      run_txn(4'hB, 0, 32'h1234_5608, 0, 0, 0, "R4 cfg without idsel");
      run_txn(4'h2, 0, 32'h8000_0010, 0, 0, 0, "R3 io cmd to memory window");
      speed_i = 2'd1;
      run_txn(4'h6, 1, 32'h8000_0010, 32'h0, 0, 0, "R5 dual upper zero");
      run_txn(4'hA, 1, 32'h0000_0010, 32'h1, 1, 0, "R5 dual cfg refused");
      bar_base_i = 64'h0000_0001_8000_0000;
      run_txn(4'h6, 1, 32'h8000_0010, 32'h1, 0, 0, "R5 dual read hit");
      run_txn(4'h6, 1, 32'h8000_0010, 32'h2, 0, 0, "R5 dual upper mismatch");
      run_txn(4'h6, 0, 32'h8000_0010, 0, 0, 0, "R3 single word upper zero");
      bar_base_i = 64'h0000_0000_8000_0000;
      sub_en_i = 1'b1;
      run_txn(4'h6, 0, 32'h8000_0100, 0, 0, 0, "R6 subtractive late");
      run_txn(4'h7, 0, 32'h8000_0100, 0, 0, 4, "R6 other at slot");
      run_txn(4'h6, 0, 32'h8000_0100, 0, 0, 3, "R6 other slow");
      sub_early_i = 1'b1;
      run_txn(4'h6, 0, 32'h8000_0100, 0, 0, 0, "R6 subtractive early");
      run_txn(4'h6, 0, 32'h8000_0100, 0, 0, 4, "R6 early other late");
      run_txn(4'hA, 0, 32'h0000_0044, 0, 1, 0, "R6 cfg stays positive");
      run_txn(4'h6, 0, 32'hA000_0000, 0, 0, 0, "R7 subtractive miss");
      sub_en_i = 1'b0; sub_early_i = 1'b0;
      bar_is_io_i = 1'b1; speed_i = 2'd0;
      run_txn(4'h2, 0, 32'h8000_0020, 0, 0, 0, "R3 io read");
      run_txn(4'h3, 0, 32'h8000_0024, 0, 0, 0, "R3 io write");
      run_txn(4'h6, 0, 32'h8000_0020, 0, 0, 0, "R3 mem cmd to io window");

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule